// File: doc/BRIEF.md
# Processor Debug Event Controller

This block decides how a processor core reacts to two debug events seen at the retire stage. The first is a return-from-interrupt event, raised when a return instruction is attempted. The second is an instruction-complete event, raised when any instruction retires. For each event it looks at the active debug mode and the machine-state debug-interrupt-enable bit. From those it chooses the response: record the event in a sticky status bit, suppress the instruction, ask the core to halt in stop state, raise a debug interrupt, or mark the event on the trace interface.

The retire stage presents one instruction slot per clock. `ret_attempt` and `cmp_valid` act as valid strobes for the slot. There is no ready signal and no back-pressure: the block takes a decision for every slot in the same cycle it is offered, and the retire stage never waits. The decision appears on registered outputs one clock after the slot. Mode, enable and interrupt-enable inputs are plain level controls. Status bits are cleared by software through a write-one-to-clear strobe.

A return seen while internal debug is active but debug interrupts are off is handled differently. Only a normal return counts, and it is recorded as imprecise. Its interrupt is held back until the enable bit rises, and it is dropped if software clears the status first.

Top module: `dbg_event_ctrl`

## Requirements
- R1: With its enable bit at 0, or with no return attempted, a return event causes no output change and no status bit is set.
- R2: When external mode or debug-wait mode is active, an enabled return of any kind does three things one cycle later: it sets status bit 0 (return), pulses `suppress` and `stop_req`, and places the return's own `cur_pc` on `stop_pc`.
- R3: In internal mode with `msr_dbg_ie`=1 (and neither halting mode active), an enabled return does three things one cycle later: it sets status bit 0, pulses `suppress` and `dbg_irq`, and places `cur_pc` on `crit_save_pc`.
- R4: In internal mode with `msr_dbg_ie`=0, `ret_kind` decides the outcome. A normal return (`ret_kind`=0) sets status bits 0 and 2 (imprecise), with no suppress, stop or interrupt. Critical (1) and machine-check (2) returns are ignored and leave the status unchanged.
- R5: Internal mode can hold a pending imprecise return, with status bits 0 and 2 both set. A 0-to-1 change of `msr_dbg_ie` then yields one `dbg_irq` pulse a cycle later, with `crit_save_pc` = `cur_pc` of the rising cycle. No pulse is raised if software cleared either bit earlier or in that same cycle.
- R6: When trace mode is active, a recorded return event pulses `trace_evt`. In trace mode alone, the event sets status bit 0 without suppress, stop or interrupt.
- R7: When external or debug-wait mode is active, an enabled instruction-complete event sets status bit 1 and pulses `stop_req` one cycle later, with `stop_pc` = next PC.
- R8: The next PC is `ret_target` when the retiring instruction is a return. Otherwise it is `br_target` when a taken branch retires. In all other cases it is `seq_pc`.
- R9: In internal mode with `msr_dbg_ie`=1, an enabled instruction-complete event sets status bit 1 and pulses `dbg_irq`, with `crit_save_pc` = next PC. In internal mode with `msr_dbg_ie`=0, or in trace mode alone, it is ignored.
- R10: External and debug-wait modes take precedence over internal mode: with both active, the response is a stop request and never an interrupt.
- R11: Status bits hold until written with 1 on `sts_clr` (bit 0 return, bit 1 complete, bit 2 imprecise). A set in the same cycle as its clear leaves the bit at 1.
- R12: A return that is suppressed does not also raise an instruction-complete event for the same slot. A return that is not suppressed may still raise one.
- R13: After reset all status bits and all pulse outputs are 0.
- R14: `suppress`, `stop_req`, `dbg_irq` and `trace_evt` are one-cycle pulses. A single event is followed by a cycle with all of them at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_ret_en | input | 1 | Return event enable |
| ctl_cmp_en | input | 1 | Instruction-complete event enable |
| mode_ext | input | 1 | External debug mode active |
| mode_wait | input | 1 | Debug-wait mode active |
| mode_int | input | 1 | Internal debug mode active |
| mode_trace | input | 1 | Trace mode active |
| msr_dbg_ie | input | 1 | Debug interrupts enabled |
| ret_attempt | input | 1 | A return instruction is attempted in this slot |
| ret_kind | input | 2 | 0 normal, 1 critical, 2 machine-check |
| cmp_valid | input | 1 | An instruction retires in this slot |
| cmp_br_taken | input | 1 | Retiring instruction is a taken branch |
| cmp_is_ret | input | 1 | Retiring instruction is a return |
| cur_pc | input | AW | Address of the instruction in the slot |
| seq_pc | input | AW | Sequential next address |
| br_target | input | AW | Branch target |
| ret_target | input | AW | Address returned to |
| sts_clr | input | 3 | Write-one-to-clear for the status bits |
| sts | output | 3 | Status: bit 0 return, bit 1 complete, bit 2 imprecise |
| suppress | output | 1 | Suppress the return instruction (pulse) |
| stop_req | output | 1 | Request stop state (pulse) |
| stop_pc | output | AW | PC to hold in stop state, valid with `stop_req` |
| dbg_irq | output | 1 | Debug interrupt request (pulse) |
| crit_save_pc | output | AW | Critical save PC, valid with `dbg_irq` |
| trace_evt | output | 1 | Return event on the trace interface (pulse) |

## Verification
The return event is driven under each mode, each return kind and both states of the interrupt enable. This separates the stop, interrupt, imprecise and trace responses, and shows that critical and machine-check returns drop out only in internal mode with interrupts off. The complete event is driven with sequential, taken-branch and return slots, so a wrong next-PC choice shows on `stop_pc` or `crit_save_pc`. Slots with both events, or with more than one mode active, test suppression masking and mode precedence. Enable-bit rises with and without an earlier or same-cycle clear test deferral against cancellation.

// File: rtl/dbgev_pkg.sv
package dbgev_pkg;
  localparam int STS_W   = 3;
  localparam int STS_RET = 0;
  localparam int STS_CMP = 1;
  localparam int STS_IDE = 2;

  typedef enum logic [1:0] {
    RK_NORMAL = 2'd0,
    RK_CRIT   = 2'd1,
    RK_MCHK   = 2'd2,
    RK_RSVD   = 2'd3
  } ret_kind_e;

  typedef struct packed {
    logic take;
    logic sup;
    logic stop;
    logic irq;
    logic trc;
    logic ide;
  } ret_act_t;
endpackage

// File: rtl/dbgev_ret_unit.sv
module dbgev_ret_unit
  import dbgev_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       attempt,
  input  logic [1:0] kind,
  input  logic       halt,
  input  logic       intr,
  input  logic       ie,
  input  logic       trace,
  output ret_act_t   act
);
  ret_kind_e k;
  logic      hit;

  assign k   = ret_kind_e'(kind);
  assign hit = en & attempt;

  always_comb begin
    act = '0;
    if (hit) begin
      if (halt) begin
        act.take = 1'b1;
        act.sup  = 1'b1;
        act.stop = 1'b1;
      end else if (intr && ie) begin
        act.take = 1'b1;
        act.sup  = 1'b1;
        act.irq  = 1'b1;
      end else if (intr) begin
        if (k == RK_NORMAL) begin
          act.take = 1'b1;
          act.ide  = 1'b1;
        end
      end else if (trace) begin
        act.take = 1'b1;
      end
    end
    act.trc = act.take & trace;
  end

  // R4
  imprecise_not_suppressed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act.ide |-> (!act.sup && !act.irq && !act.stop));

  // R10
  halt_never_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> !act.irq);
endmodule

// File: rtl/dbgev_cmp_unit.sv
module dbgev_cmp_unit #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          valid,
  input  logic          blocked,
  input  logic          br_taken,
  input  logic          is_ret,
  input  logic [AW-1:0] seq_pc,
  input  logic [AW-1:0] br_target,
  input  logic [AW-1:0] ret_target,
  input  logic          halt,
  input  logic          intr,
  input  logic          ie,
  output logic          take,
  output logic          stop,
  output logic          irq,
  output logic [AW-1:0] next_pc
);
  logic hit;

  always_comb begin
    if (is_ret)        next_pc = ret_target;
    else if (br_taken) next_pc = br_target;
    else               next_pc = seq_pc;
  end

  assign hit = en & valid & ~blocked;

  always_comb begin
    stop = 1'b0;
    irq  = 1'b0;
    if (hit) begin
      if (halt)             stop = 1'b1;
      else if (intr && ie)  irq  = 1'b1;
    end
    take = stop | irq;
  end

  // R12
  blocked_no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |-> !take);

  // R9
  off_no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt && !(intr && ie)) |-> !take);
endmodule

// File: rtl/dbgev_sts_reg.sv
module dbgev_sts_reg #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] sts
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sts[i] <= 1'b0;
      else if (set[i]) sts[i] <= 1'b1;
      else if (clr[i]) sts[i] <= 1'b0;
    end

    // R11
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> sts[i]);

    // R11
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !set[i]) |=> !sts[i]);

    // R11
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!set[i] && !clr[i]) |=> (sts[i] == $past(sts[i])));
  end
endmodule

// File: rtl/dbg_event_ctrl.sv
module dbg_event_ctrl
  import dbgev_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_ret_en,
  input  logic             ctl_cmp_en,
  input  logic             mode_ext,
  input  logic             mode_wait,
  input  logic             mode_int,
  input  logic             mode_trace,
  input  logic             msr_dbg_ie,
  input  logic             ret_attempt,
  input  logic [1:0]       ret_kind,
  input  logic             cmp_valid,
  input  logic             cmp_br_taken,
  input  logic             cmp_is_ret,
  input  logic [AW-1:0]    cur_pc,
  input  logic [AW-1:0]    seq_pc,
  input  logic [AW-1:0]    br_target,
  input  logic [AW-1:0]    ret_target,
  input  logic [STS_W-1:0] sts_clr,
  output logic [STS_W-1:0] sts,
  output logic             suppress,
  output logic             stop_req,
  output logic [AW-1:0]    stop_pc,
  output logic             dbg_irq,
  output logic [AW-1:0]    crit_save_pc,
  output logic             trace_evt
);
  logic             halt;
  ret_act_t         ra;
  logic             c_take, c_stop, c_irq;
  logic [AW-1:0]    nxt_pc;
  logic [STS_W-1:0] sts_set;
  logic [STS_W-1:0] sts_after_clr;
  logic             ie_q;
  logic             defer;

  assign halt = mode_ext | mode_wait;

  dbgev_ret_unit u_ret (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (ctl_ret_en),
    .attempt (ret_attempt),
    .kind    (ret_kind),
    .halt    (halt),
    .intr    (mode_int),
    .ie      (msr_dbg_ie),
    .trace   (mode_trace),
    .act     (ra)
  );

  dbgev_cmp_unit #(.AW(AW)) u_cmp (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (ctl_cmp_en),
    .valid      (cmp_valid),
    .blocked    (ra.sup),
    .br_taken   (cmp_br_taken),
    .is_ret     (cmp_is_ret),
    .seq_pc     (seq_pc),
    .br_target  (br_target),
    .ret_target (ret_target),
    .halt       (halt),
    .intr       (mode_int),
    .ie         (msr_dbg_ie),
    .take       (c_take),
    .stop       (c_stop),
    .irq        (c_irq),
    .next_pc    (nxt_pc)
  );

  always_comb begin
    sts_set          = '0;
    sts_set[STS_RET] = ra.take;
    sts_set[STS_CMP] = c_take;
    sts_set[STS_IDE] = ra.ide;
  end

  dbgev_sts_reg #(.W(STS_W)) u_sts (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (sts_set),
    .clr   (sts_clr),
    .sts   (sts)
  );

  // Deferred interrupt: enable rises while an imprecise return is still recorded.
  assign sts_after_clr = sts & ~sts_clr;
  assign defer = mode_int & ~halt & msr_dbg_ie & ~ie_q
               & sts_after_clr[STS_RET] & sts_after_clr[STS_IDE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q         <= 1'b0;
      suppress     <= 1'b0;
      stop_req     <= 1'b0;
      dbg_irq      <= 1'b0;
      trace_evt    <= 1'b0;
      stop_pc      <= '0;
      crit_save_pc <= '0;
    end else begin
      ie_q      <= msr_dbg_ie;
      suppress  <= ra.sup;
      stop_req  <= ra.stop | c_stop;
      dbg_irq   <= ra.irq | c_irq | defer;
      trace_evt <= ra.trc;
      if (ra.stop)    stop_pc <= cur_pc;
      else if (c_stop) stop_pc <= nxt_pc;
      if (ra.irq)      crit_save_pc <= cur_pc;
      else if (c_irq)  crit_save_pc <= nxt_pc;
      else if (defer)  crit_save_pc <= cur_pc;
    end
  end

  // R2
  stop_only_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |-> $past(mode_ext || mode_wait));

  // R10
  irq_not_in_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_irq |-> $past(mode_int && !mode_ext && !mode_wait));

  // R3
  suppress_has_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
    suppress |-> (stop_req ^ dbg_irq));

  // R6
  trace_needs_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trace_evt |-> ($past(mode_trace) && sts[STS_RET]));

  // R5
  defer_needs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_irq && !$past(ret_attempt) && !$past(cmp_valid)) |-> $past(msr_dbg_ie && !ie_q));
endmodule

// File: tb/dbg_event_ctrl_tb_top.sv
module dbg_event_ctrl_tb_top;
  localparam int AW = 32;
  localparam logic [AW-1:0] CUR = 32'h100, SEQ = 32'h104, BRT = 32'h200, RTT = 32'h300;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_ret_en, ctl_cmp_en, mode_ext, mode_wait, mode_int, mode_trace, msr_dbg_ie;
  logic ret_attempt, cmp_valid, cmp_br_taken, cmp_is_ret;
  logic [1:0] ret_kind;
  logic [2:0] sts_clr, sts;
  logic suppress, stop_req, dbg_irq, trace_evt;
  logic [AW-1:0] stop_pc, crit_save_pc;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dbg_event_ctrl #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_ret_en(ctl_ret_en), .ctl_cmp_en(ctl_cmp_en),
    .mode_ext(mode_ext), .mode_wait(mode_wait), .mode_int(mode_int), .mode_trace(mode_trace),
    .msr_dbg_ie(msr_dbg_ie), .ret_attempt(ret_attempt), .ret_kind(ret_kind),
    .cmp_valid(cmp_valid), .cmp_br_taken(cmp_br_taken), .cmp_is_ret(cmp_is_ret),
    .cur_pc(CUR), .seq_pc(SEQ), .br_target(BRT), .ret_target(RTT), .sts_clr(sts_clr),
    .sts(sts), .suppress(suppress), .stop_req(stop_req), .stop_pc(stop_pc),
    .dbg_irq(dbg_irq), .crit_save_pc(crit_save_pc), .trace_evt(trace_evt)
  );

  // md = {trace,int,wait,ext}; ctl = {ie,ret_en,cmp_en,ret_attempt};
  // inp = {cmp_valid,br_taken,is_ret}; out = {suppress,stop,irq,trace}
  typedef struct packed {
    logic [3:0]  md;
    logic [3:0]  ctl;
    logic [1:0]  kind;
    logic [2:0]  inp;
    logic [3:0]  out;
    logic [2:0]  st;
    logic [11:0] pc;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VT [NV] = '{
    '{4'b0100, 4'b1001, 2'd0, 3'b000, 4'b0000, 3'b000, 12'h000, 4'd1},  // R1 enable off
    '{4'b0001, 4'b0100, 2'd0, 3'b000, 4'b0000, 3'b000, 12'h000, 4'd1},  // R1 no attempt
    '{4'b0001, 4'b0101, 2'd0, 3'b000, 4'b1100, 3'b001, 12'h100, 4'd2},  // R2 ext
    '{4'b0010, 4'b0101, 2'd1, 3'b000, 4'b1100, 3'b001, 12'h100, 4'd2},  // R2 wait, critical
    '{4'b0100, 4'b1101, 2'd2, 3'b000, 4'b1010, 3'b001, 12'h100, 4'd3},  // R3
    '{4'b0100, 4'b0101, 2'd0, 3'b000, 4'b0000, 3'b101, 12'h000, 4'd4},  // R4 normal imprecise
    '{4'b0100, 4'b0101, 2'd1, 3'b000, 4'b0000, 3'b000, 12'h000, 4'd4},  // R4 critical ignored
    '{4'b0100, 4'b0101, 2'd2, 3'b000, 4'b0000, 3'b000, 12'h000, 4'd4},  // R4 mcheck ignored
    '{4'b1000, 4'b0101, 2'd1, 3'b000, 4'b0001, 3'b001, 12'h000, 4'd6},  // R6 trace
    '{4'b0001, 4'b0010, 2'd0, 3'b100, 4'b0100, 3'b010, 12'h104, 4'd7},  // R7 sequential
    '{4'b0001, 4'b0010, 2'd0, 3'b110, 4'b0100, 3'b010, 12'h200, 4'd8},  // R8 branch
    '{4'b0001, 4'b0010, 2'd0, 3'b101, 4'b0100, 3'b010, 12'h300, 4'd8},  // R8 return target
    '{4'b0010, 4'b0010, 2'd0, 3'b111, 4'b0100, 3'b010, 12'h300, 4'd8},  // R8 return wins
    '{4'b0100, 4'b1010, 2'd0, 3'b110, 4'b0010, 3'b010, 12'h200, 4'd9},  // R9 irq
    '{4'b0100, 4'b0010, 2'd0, 3'b100, 4'b0000, 3'b000, 12'h000, 4'd9},  // R9 ie off
    '{4'b1000, 4'b0010, 2'd0, 3'b100, 4'b0000, 3'b000, 12'h000, 4'd9},  // R9 trace only
    '{4'b0101, 4'b1101, 2'd0, 3'b000, 4'b1100, 3'b001, 12'h100, 4'd10}, // R10 ext over int
    '{4'b1100, 4'b1101, 2'd0, 3'b000, 4'b1011, 3'b001, 12'h100, 4'd6},  // R6 trace with int
    '{4'b0001, 4'b0111, 2'd0, 3'b101, 4'b1100, 3'b001, 12'h100, 4'd12}, // R12 suppressed
    '{4'b0100, 4'b0111, 2'd0, 3'b101, 4'b0000, 3'b101, 12'h000, 4'd12}  // R12 not suppressed
  };

  task automatic chk(input bit ok, input int req, input logic [31:0] got, input logic [31:0] exp,
                     input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s got %0h exp %0h", req, what, got, exp);
    end
  endtask

  task automatic idle(input logic [3:0] md, input logic ie);
    {mode_trace, mode_int, mode_wait, mode_ext} = md;
    msr_dbg_ie = ie;
    ctl_ret_en = 1'b0; ctl_cmp_en = 1'b0; ret_attempt = 1'b0; ret_kind = 2'd0;
    cmp_valid = 1'b0; cmp_br_taken = 1'b0; cmp_is_ret = 1'b0; sts_clr = 3'b000;
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic apply(input vec_t v);
    {mode_trace, mode_int, mode_wait, mode_ext} = v.md;
    {msr_dbg_ie, ctl_ret_en, ctl_cmp_en, ret_attempt} = v.ctl;
    ret_kind = v.kind;
    {cmp_valid, cmp_br_taken, cmp_is_ret} = v.inp;
  endtask

  task automatic clear_all();
    idle(4'b0000, 1'b0); sts_clr = 3'b111; cyc(); sts_clr = 3'b000;
  endtask

  task automatic make_pending();
    clear_all();
    idle(4'b0100, 1'b0); ctl_ret_en = 1'b1; ret_attempt = 1'b1; ret_kind = 2'd0;
    cyc();
    idle(4'b0100, 1'b0); cyc();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(4'b0000, 1'b0);
    repeat (3) @(negedge clk);
    // R13 reset state, inputs idle
    chk(sts == 3'b000, 13, {29'd0, sts}, 0, "status at reset");
    chk({suppress, stop_req, dbg_irq, trace_evt} == 4'b0000, 13,
        {28'd0, suppress, stop_req, dbg_irq, trace_evt}, 0, "pulses at reset");
    rst_n = 1'b1;
    cyc();
    chk(sts == 3'b000, 13, {29'd0, sts}, 0, "status after release");

    for (int i = 0; i < NV; i++) begin
      clear_all();
      apply(VT[i]);
      cyc();
      idle(4'b0000, 1'b0);
      chk({suppress, stop_req, dbg_irq, trace_evt} == VT[i].out, int'(VT[i].req),
          {28'd0, suppress, stop_req, dbg_irq, trace_evt}, {28'd0, VT[i].out}, "pulses");
      chk(sts == VT[i].st, int'(VT[i].req), {29'd0, sts}, {29'd0, VT[i].st}, "status");
      if (VT[i].out[2])
        chk(stop_pc == {20'd0, VT[i].pc}, int'(VT[i].req), stop_pc, {20'd0, VT[i].pc}, "stop_pc");
      if (VT[i].out[1])
        chk(crit_save_pc == {20'd0, VT[i].pc}, int'(VT[i].req), crit_save_pc,
            {20'd0, VT[i].pc}, "crit_save_pc");
      cyc();
      // R14 pulses last one cycle
      chk({suppress, stop_req, dbg_irq, trace_evt} == 4'b0000, 14,
          {28'd0, suppress, stop_req, dbg_irq, trace_evt}, 0, "pulse width");
    end

    // R5 deferred interrupt on enable rise
    make_pending();
    chk(dbg_irq == 1'b0, 5, {31'd0, dbg_irq}, 0, "no irq while ie off");
    idle(4'b0100, 1'b1); cyc();
    chk(dbg_irq == 1'b1, 5, {31'd0, dbg_irq}, 1, "deferred irq");
    chk(crit_save_pc == CUR, 5, crit_save_pc, CUR, "deferred save pc");
    chk(suppress == 1'b0, 5, {31'd0, suppress}, 0, "deferred no suppress");
    cyc();
    chk(dbg_irq == 1'b0, 5, {31'd0, dbg_irq}, 0, "deferred irq once");

    // R5 cancelled by earlier clear
    make_pending();
    idle(4'b0100, 1'b0); sts_clr = 3'b001; cyc();
    idle(4'b0100, 1'b1); cyc();
    chk(dbg_irq == 1'b0, 5, {31'd0, dbg_irq}, 0, "cancelled by clear");

    // R5 cancelled by same-cycle clear
    make_pending();
    idle(4'b0100, 1'b1); sts_clr = 3'b001; cyc();
    chk(dbg_irq == 1'b0, 5, {31'd0, dbg_irq}, 0, "cancelled same cycle");

    // R11 set beats clear, clear touches only its bit
    clear_all();
    idle(4'b0001, 1'b0); ctl_cmp_en = 1'b1; cmp_valid = 1'b1; cyc();
    idle(4'b0001, 1'b0); ctl_ret_en = 1'b1; ret_attempt = 1'b1; sts_clr = 3'b001; cyc();
    chk(sts == 3'b011, 11, {29'd0, sts}, 32'h3, "set wins over clear");
    idle(4'b0000, 1'b0); cyc();
    chk(sts == 3'b011, 11, {29'd0, sts}, 32'h3, "sticky");
    sts_clr = 3'b001; cyc();
    idle(4'b0000, 1'b0);
    chk(sts == 3'b010, 11, {29'd0, sts}, 32'h2, "w1c one bit");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule